// File: doc/BRIEF.md
# Oversampling Asynchronous Receiver with Per-Character Status Queue

This block takes an asynchronous serial line and turns it into a stream of characters. Each character is delivered with its own error flags through a four-slot queue. Sampling is paced by a sample-tick enable that runs at either sixteen times or once per bit. In sixteen-times mode a start bit must still be low at its middle to be accepted. The character length, parity mode and tick rate are set on configuration inputs. Software or a downstream engine pops one entry at a time. Each entry shows the data together with its parity, framing, overrun and break flags.

The receiver also does three more things:
- It can compare every finished character with a programmed value and pulse an event when they are equal.
- It reports the start and the end of a line break as two separate pulses.
- It raises a queue-full output that can be used to hold off the far-end transmitter.

After a stop bit that is received low, the receiver waits half a bit before it looks for the next start bit.

Top module: `rxs_top`

## Requirements
- R1: After reset, `rd_valid`, `fifo_full`, `ev_match`, `ev_ovr`, `ev_brk_start` and `ev_brk_end` are all 0.
- R2: `cfg_len` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. Bits arrive least significant first. The stored byte is right-aligned, and its unused upper bits are 0.
- R3: `cfg_par` selects the parity mode. Code 0 is none, code 1 is even and code 2 is odd; in each case the parity bit follows the data bits. Code 3 expects the parity bit to equal `cfg_par_force`. `rd_perr` is set on an entry whose received parity bit differs from the expected one. It is never set when there is no parity.
- R4: With `cfg_x16`=1, each bit is sampled on the 8th tick after the tick that saw the start edge, and then every 16 ticks. If the line is high again at the start-bit sample, the character is dropped and no entry is stored.
- R5: With `cfg_x16`=0, every tick is one bit time. The tick that sees the line low is the start bit, and the next tick samples data bit 0.
- R6: A low stop bit sets `rd_ferr` on that entry. The start-bit search resumes half a bit later: after 8 ticks in 16X mode, or 1 tick in 1X mode.
- R7: A break is a character whose data bits, parity bit (if any) and stop bit are all 0. It is stored once, with data 0 and both `rd_ferr` and `rd_brk` set, and `ev_brk_start` pulses. Nothing more is stored while the line stays low. When the line returns high, `ev_brk_end` pulses.
- R8: When `cfg_cmp_en`=1 and a non-break character equals `cfg_cmp_val`, `ev_match` pulses for one cycle. It never pulses when `cfg_cmp_en`=0.
- R9: The queue holds four entries in arrival order. The head is shown on the read outputs while `rd_valid`=1, and `rd_en` removes it.
- R10: If a character completes while four entries are held and none is being read, the character is discarded. `rd_ovr` is set on the newest stored entry and `ev_ovr` pulses.
- R11: `fifo_full` is 1 exactly when four entries are held.
- R12: Without `samp_en`, the receiver ignores the line: no entry and no event results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| samp_en | input | 1 | sample tick (16X or 1X bit rate) |
| rx_in | input | 1 | serial line, idle high |
| cfg_len | input | 2 | character length code |
| cfg_par | input | 2 | parity mode code |
| cfg_par_force | input | 1 | expected parity value in forced mode |
| cfg_x16 | input | 1 | 1: sixteen ticks per bit, 0: one tick per bit |
| cfg_cmp_en | input | 1 | enable character compare |
| cfg_cmp_val | input | 8 | compare value |
| rd_en | input | 1 | pop head entry |
| rd_valid | output | 1 | queue holds at least one entry |
| rd_data | output | 8 | head data byte |
| rd_perr | output | 1 | head parity error flag |
| rd_ferr | output | 1 | head framing error flag |
| rd_ovr | output | 1 | head overrun flag |
| rd_brk | output | 1 | head break flag |
| fifo_full | output | 1 | four entries held |
| ev_match | output | 1 | compare match pulse |
| ev_ovr | output | 1 | overrun pulse |
| ev_brk_start | output | 1 | break begin pulse |
| ev_brk_end | output | 1 | break end pulse |

## Verification
Some rules are checked on every cycle:
- An overrun pulse only appears while the queue is full and stays full.
- The full flag implies a valid head.
- An entry never disappears without a read.
- Break begin and end never pulse together.
- A match needs the compare enable.
- A character is only stored after a sample tick.

Only the bench scenarios can show whether the bit sampling lands in the right place. The same holds for the parity and framing flag values, false-start rejection, the recovery after a framing error, break behaviour and the overrun marking. The bench shows these by comparing the popped entries with what it sent.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int CHAR_W = 8;

    localparam logic [1:0] PAR_NONE  = 2'b00;
    localparam logic [1:0] PAR_EVEN  = 2'b01;
    localparam logic [1:0] PAR_ODD   = 2'b10;
    localparam logic [1:0] PAR_FIXED = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP  = 3'd4,
        S_HOLD  = 3'd5,
        S_BRK   = 3'd6
    } rx_state_t;

    typedef struct packed {
        logic              brk;
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/rxs_frame.sv
module rxs_frame
    import rxs_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_en,
    input  logic              rx_in,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_par_force,
    input  logic              cfg_x16,
    input  logic              cfg_cmp_en,
    input  logic [CHAR_W-1:0] cfg_cmp_val,
    output logic              push,
    output rx_entry_t         push_ent,
    output logic              ev_match,
    output logic              ev_brk_start,
    output logic              ev_brk_end
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID_C  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_t         st;
        logic [CW-1:0]     cnt;
        logic [2:0]        bidx;
        logic [CHAR_W-1:0] sh;
        logic              pbit;
        logic              push;
        rx_entry_t         ent;
        logic              match;
        logic              bstart;
        logic              bend;
    } frm_t;

    frm_t q, d;

    logic              rxb;
    logic [CW-1:0]     lim_mid;
    logic [CW-1:0]     lim_bit;
    logic [2:0]        last_b;
    logic              par_en;
    logic [CHAR_W-1:0] word;
    logic              exp_par;
    logic              is_brk;

    always_comb begin
        rxb     = q.sync[1];
        lim_mid = cfg_x16 ? MID_C : '0;
        lim_bit = cfg_x16 ? LAST_C : '0;
        last_b  = {1'b0, cfg_len} + 3'd4;
        par_en  = (cfg_par != PAR_NONE);
        word    = q.sh >> (2'd3 - cfg_len);
        case (cfg_par)
            PAR_EVEN: exp_par = ^word;
            PAR_ODD:  exp_par = ~^word;
            default:  exp_par = cfg_par_force;
        endcase
        is_brk  = !rxb && (word == '0) && (!par_en || !q.pbit);

        d        = q;
        d.sync   = {q.sync[0], rx_in};
        d.push   = 1'b0;
        d.match  = 1'b0;
        d.bstart = 1'b0;
        d.bend   = 1'b0;

        if (samp_en) begin
            case (q.st)
                S_IDLE: begin
                    if (!rxb) begin
                        d.cnt  = '0;
                        d.bidx = '0;
                        d.sh   = '0;
                        d.pbit = 1'b0;
                        d.st   = cfg_x16 ? S_START : S_DATA;
                    end
                end
                S_START: begin
                    if (q.cnt == lim_mid) begin
                        d.cnt = '0;
                        d.st  = rxb ? S_IDLE : S_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (q.cnt == lim_bit) begin
                        d.cnt = '0;
                        d.sh  = {rxb, q.sh[CHAR_W-1:1]};
                        if (q.bidx == last_b) begin
                            d.st = par_en ? S_PAR : S_STOP;
                        end else begin
                            d.bidx = q.bidx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                S_PAR: begin
                    if (q.cnt == lim_bit) begin
                        d.cnt  = '0;
                        d.pbit = rxb;
                        d.st   = S_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                S_STOP: begin
                    if (q.cnt == lim_bit) begin
                        d.cnt      = '0;
                        d.push     = 1'b1;
                        d.ent.data = word;
                        d.ent.perr = par_en && (q.pbit != exp_par);
                        d.ent.ferr = !rxb;
                        d.ent.ovr  = 1'b0;
                        d.ent.brk  = is_brk;
                        d.match    = cfg_cmp_en && !is_brk && (word == cfg_cmp_val);
                        if (is_brk) begin
                            d.bstart = 1'b1;
                            d.st     = S_BRK;
                        end else if (!rxb) begin
                            d.st = S_HOLD;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                S_HOLD: begin
                    if (q.cnt == lim_mid) begin
                        d.cnt = '0;
                        d.st  = S_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                S_BRK: begin
                    if (rxb) begin
                        d.bend = 1'b1;
                        d.st   = S_IDLE;
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign push         = q.push;
    assign push_ent     = q.ent;
    assign ev_match     = q.match;
    assign ev_brk_start = q.bstart;
    assign ev_brk_end   = q.bend;
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo
    import rxs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t push_ent,
    input  logic      rd_en,
    output rx_entry_t rd_ent,
    output logic      rd_valid,
    output logic      full,
    output logic      ev_ovr
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] TOP_P = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovr;
    } ctl_t;

    ctl_t      q, d;
    rx_entry_t mem_q [DEPTH];
    rx_entry_t mem_d [DEPTH];
    logic      pop;
    logic      room;
    logic      take;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == TOP_P) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
        return (p == '0) ? TOP_P : p - 1'b1;
    endfunction

    always_comb begin
        d     = q;
        mem_d = mem_q;
        d.ovr = 1'b0;
        pop   = rd_en && (q.cnt != '0);
        room  = (q.cnt != FULL_C) || pop;
        take  = push && room;
        if (pop) begin
            d.rd = ptr_inc(q.rd);
        end
        if (take) begin
            mem_d[q.wr] = push_ent;
            d.wr        = ptr_inc(q.wr);
        end else if (push) begin
            mem_d[ptr_dec(q.wr)].ovr = 1'b1;
            d.ovr                    = 1'b1;
        end
        d.cnt = q.cnt + CW'(take) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            q     <= d;
            mem_q <= mem_d;
        end
    end

    assign rd_ent   = mem_q[q.rd];
    assign rd_valid = (q.cnt != '0);
    assign full     = (q.cnt == FULL_C);
    assign ev_ovr   = q.ovr;
endmodule

// File: rtl/rxs_top.sv
module rxs_top
    import rxs_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        samp_en,
    input  logic        rx_in,
    input  logic [1:0]  cfg_len,
    input  logic [1:0]  cfg_par,
    input  logic        cfg_par_force,
    input  logic        cfg_x16,
    input  logic        cfg_cmp_en,
    input  logic [7:0]  cfg_cmp_val,
    input  logic        rd_en,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        rd_perr,
    output logic        rd_ferr,
    output logic        rd_ovr,
    output logic        rd_brk,
    output logic        fifo_full,
    output logic        ev_match,
    output logic        ev_ovr,
    output logic        ev_brk_start,
    output logic        ev_brk_end
);
    logic      frm_push;
    rx_entry_t frm_ent;
    rx_entry_t head;

    rxs_frame #(.OVS(OVS)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .samp_en       (samp_en),
        .rx_in         (rx_in),
        .cfg_len       (cfg_len),
        .cfg_par       (cfg_par),
        .cfg_par_force (cfg_par_force),
        .cfg_x16       (cfg_x16),
        .cfg_cmp_en    (cfg_cmp_en),
        .cfg_cmp_val   (cfg_cmp_val),
        .push          (frm_push),
        .push_ent      (frm_ent),
        .ev_match      (ev_match),
        .ev_brk_start  (ev_brk_start),
        .ev_brk_end    (ev_brk_end)
    );

    rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (frm_push),
        .push_ent (frm_ent),
        .rd_en    (rd_en),
        .rd_ent   (head),
        .rd_valid (rd_valid),
        .full     (fifo_full),
        .ev_ovr   (ev_ovr)
    );

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;
    assign rd_ovr  = head.ovr;
    assign rd_brk  = head.brk;
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk (
    input logic clk,
    input logic rst_n,
    input logic samp_en,
    input logic cfg_cmp_en,
    input logic rd_en,
    input logic rd_valid,
    input logic fifo_full,
    input logic ev_match,
    input logic ev_ovr,
    input logic ev_brk_start,
    input logic ev_brk_end,
    input logic push
);
    a_r10_ovr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovr |-> (fifo_full && $past(fifo_full)));

    a_r11_full_has_head: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> rd_valid);

    a_r9_entry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> rd_valid);

    a_r7_brk_events_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_brk_start && ev_brk_end));

    a_r8_match_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        ev_match |-> $past(cfg_cmp_en));

    a_r12_push_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(samp_en));
endmodule

bind rxs_top rxs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .samp_en      (samp_en),
    .cfg_cmp_en   (cfg_cmp_en),
    .rd_en        (rd_en),
    .rd_valid     (rd_valid),
    .fifo_full    (fifo_full),
    .ev_match     (ev_match),
    .ev_ovr       (ev_ovr),
    .ev_brk_start (ev_brk_start),
    .ev_brk_end   (ev_brk_end),
    .push         (frm_push)
);

// File: tb/tb_rxs_top.sv
module tb_rxs_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_en = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_par_force = 1'b0;
    logic       cfg_x16 = 1'b1;
    logic       cfg_cmp_en = 1'b0;
    logic [7:0] cfg_cmp_val = 8'h00;
    logic       rd_en = 1'b0;
    logic       rd_valid, rd_perr, rd_ferr, rd_ovr, rd_brk, fifo_full;
    logic [7:0] rd_data;
    logic       ev_match, ev_ovr, ev_brk_start, ev_brk_end;

    int total = 0;
    int bad = 0;
    int tdiv = 1;
    int tcnt = 0;
    bit tick_off = 1'b0;
    bit rd_go = 1'b1;
    bit finished = 1'b0;
    int n_match = 0, n_ovr = 0, n_bs = 0, n_be = 0;

    logic [11:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    rxs_top dut (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_par_force(cfg_par_force),
        .cfg_x16(cfg_x16), .cfg_cmp_en(cfg_cmp_en), .cfg_cmp_val(cfg_cmp_val),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rd_ovr(rd_ovr), .rd_brk(rd_brk), .fifo_full(fifo_full),
        .ev_match(ev_match), .ev_ovr(ev_ovr), .ev_brk_start(ev_brk_start),
        .ev_brk_end(ev_brk_end)
    );

    always @(negedge clk) begin
        if (tick_off) begin
            samp_en <= 1'b0;
            tcnt    <= 0;
        end else if (tcnt >= tdiv - 1) begin
            samp_en <= 1'b1;
            tcnt    <= 0;
        end else begin
            samp_en <= 1'b0;
            tcnt    <= tcnt + 1;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (ev_match)     n_match++;
            if (ev_ovr)       n_ovr++;
            if (ev_brk_start) n_bs++;
            if (ev_brk_end)   n_be++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_ent(input logic [7:0] d, input bit perr, input bit ferr,
                              input bit ovr, input bit brk, input string tag);
        exp_q.push_back({brk, ovr, ferr, perr, d});
        tag_q.push_back(tag);
    endtask

    // monitor: pops the queue and compares each delivered entry
    initial begin
        forever begin
            @(negedge clk);
            if (rd_en) begin
                rd_en = 1'b0;
            end else if (rd_go && rd_valid && rst_n) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected entry", int'(rd_data), 0);
                end else begin
                    logic [11:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({rd_brk, rd_ovr, rd_ferr, rd_perr, rd_data} == e, t,
                          "entry {brk,ovr,ferr,perr,data}",
                          int'({rd_brk, rd_ovr, rd_ferr, rd_perr, rd_data}), int'(e));
                end
                rd_en = 1'b1;
            end
        end
    end

    task automatic wait_tick();
        do @(posedge clk); while (samp_en !== 1'b1);
        #1;
    endtask

    task automatic hold_bit(input logic b);
        rx_in = b;
        repeat (cfg_x16 ? 16 : 1) wait_tick();
    endtask

    function automatic logic par_of(input logic [7:0] d);
        case (cfg_par)
            2'd1:    return ^d;
            2'd2:    return ~^d;
            default: return cfg_par_force;
        endcase
    endfunction

    function automatic logic [7:0] mask(input logic [7:0] d);
        return d & (8'hFF >> (3 - cfg_len));
    endfunction

    task automatic send_char(input logic [7:0] d, input bit good_par, input logic stopv,
                             input int idle_bits);
        logic [7:0] m;
        logic       p;
        m = mask(d);
        p = par_of(m);
        wait_tick();
        hold_bit(1'b0);
        for (int i = 0; i < int'(cfg_len) + 5; i++) hold_bit(m[i]);
        if (cfg_par != 2'd0) hold_bit(good_par ? p : ~p);
        hold_bit(stopv);
        for (int i = 0; i < idle_bits; i++) hold_bit(1'b1);
    endtask

    task automatic drain(input string req);
        int w;
        w = 0;
        while (exp_q.size() != 0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, "expected entries delivered", exp_q.size(), 0);
        check(rd_valid == 1'b0, req, "queue empty after drain", int'(rd_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(rd_valid == 0 && fifo_full == 0, "R1", "valid/full at reset",
              int'({rd_valid, fifo_full}), 0);
        check({ev_match, ev_ovr, ev_brk_start, ev_brk_end} == 4'b0, "R1", "events at reset",
              int'({ev_match, ev_ovr, ev_brk_start, ev_brk_end}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(rd_valid == 0 && fifo_full == 0, "R1", "valid/full after reset",
              int'({rd_valid, fifo_full}), 0);

        // R2: lengths, 16X, no parity
        cfg_par = 2'd0;
        cfg_len = 2'd3; expect_ent(8'hA5, 0, 0, 0, 0, "R2"); send_char(8'hA5, 1, 1'b1, 1);
        cfg_len = 2'd0; expect_ent(8'h1B, 0, 0, 0, 0, "R2"); send_char(8'hFB, 1, 1'b1, 1);
        cfg_len = 2'd1; expect_ent(8'h2D, 0, 0, 0, 0, "R2"); send_char(8'hED, 1, 1'b1, 1);
        drain("R2");

        // R3: parity modes
        cfg_len = 2'd2; cfg_par = 2'd1;
        expect_ent(8'h35, 0, 0, 0, 0, "R3"); send_char(8'h35, 1, 1'b1, 1);
        expect_ent(8'h35, 1, 0, 0, 0, "R3"); send_char(8'h35, 0, 1'b1, 1);
        cfg_len = 2'd1; cfg_par = 2'd2;
        expect_ent(8'h2C, 0, 0, 0, 0, "R3"); send_char(8'h2C, 1, 1'b1, 1);
        expect_ent(8'h2C, 1, 0, 0, 0, "R3"); send_char(8'h2C, 0, 1'b1, 1);
        cfg_len = 2'd3; cfg_par = 2'd3; cfg_par_force = 1'b1;
        expect_ent(8'h00, 0, 0, 0, 0, "R3"); send_char(8'h00, 1, 1'b1, 1);
        expect_ent(8'h81, 1, 0, 0, 0, "R3"); send_char(8'h81, 0, 1'b1, 1);
        drain("R3");

        // R4: false start rejected, then a real character
        cfg_par = 2'd0; cfg_len = 2'd3;
        wait_tick();
        rx_in = 1'b0;
        repeat (4) wait_tick();
        rx_in = 1'b1;
        repeat (40) wait_tick();
        check(rd_valid == 1'b0, "R4", "false start stored nothing", int'(rd_valid), 0);
        expect_ent(8'h3C, 0, 0, 0, 0, "R4"); send_char(8'h3C, 1, 1'b1, 1);
        drain("R4");

        // R12: slower tick, then ticks off
        tdiv = 3;
        expect_ent(8'h96, 0, 0, 0, 0, "R12"); send_char(8'h96, 1, 1'b1, 1);
        drain("R12");
        tdiv = 1;
        tick_off = 1'b1;
        repeat (3) @(negedge clk);
        begin
            int bs0;
            bs0 = n_bs;
            rx_in = 1'b0;
            repeat (400) @(negedge clk);
            rx_in = 1'b1;
            repeat (10) @(negedge clk);
            tick_off = 1'b0;
            repeat (300) @(negedge clk);
            check(rd_valid == 1'b0 && n_bs == bs0, "R12", "no entry/event without ticks",
                  int'(rd_valid), 0);
        end

        // R5: 1X mode with even parity
        cfg_x16 = 1'b0; tdiv = 4; cfg_par = 2'd1;
        wait_tick(); wait_tick();
        expect_ent(8'hC3, 0, 0, 0, 0, "R5"); send_char(8'hC3, 1, 1'b1, 2);
        expect_ent(8'h4E, 1, 0, 0, 0, "R5"); send_char(8'h4E, 0, 1'b1, 2);
        drain("R5");
        cfg_x16 = 1'b1; tdiv = 1; cfg_par = 2'd0;
        repeat (40) wait_tick();

        // R6: framing error followed straight away by a start bit
        cfg_len = 2'd2; cfg_par = 2'd2;
        expect_ent(8'h5A, 0, 1, 0, 0, "R6"); send_char(8'h5A, 1, 1'b0, 0);
        expect_ent(8'h33, 0, 0, 0, 0, "R6"); send_char(8'h33, 1, 1'b1, 1);
        drain("R6");

        // R7: break
        cfg_len = 2'd3; cfg_par = 2'd0;
        begin
            int bs0, be0;
            bs0 = n_bs; be0 = n_be;
            expect_ent(8'h00, 0, 1, 0, 1, "R7");
            wait_tick();
            for (int i = 0; i < 30; i++) hold_bit(1'b0);
            check(n_bs == bs0 + 1, "R7", "break start pulses", n_bs - bs0, 1);
            check(n_be == be0, "R7", "no break end while low", n_be - be0, 0);
            hold_bit(1'b1); hold_bit(1'b1);
            check(n_be == be0 + 1, "R7", "break end pulses", n_be - be0, 1);
            drain("R7");
        end
        expect_ent(8'h7E, 0, 0, 0, 0, "R7"); send_char(8'h7E, 1, 1'b1, 1);
        drain("R7");

        // R8: compare
        begin
            int m0;
            cfg_cmp_val = 8'h41; cfg_cmp_en = 1'b1;
            m0 = n_match;
            expect_ent(8'h41, 0, 0, 0, 0, "R8"); send_char(8'h41, 1, 1'b1, 1);
            expect_ent(8'h42, 0, 0, 0, 0, "R8"); send_char(8'h42, 1, 1'b1, 1);
            drain("R8");
            check(n_match == m0 + 1, "R8", "one match", n_match - m0, 1);
            cfg_cmp_en = 1'b0;
            expect_ent(8'h41, 0, 0, 0, 0, "R8"); send_char(8'h41, 1, 1'b1, 1);
            drain("R8");
            check(n_match == m0 + 1, "R8", "no match when disabled", n_match - m0, 1);
        end

        // R9, R10, R11: fill, overrun, ordering
        begin
            int o0;
            o0 = n_ovr;
            rd_go = 1'b0;
            send_char(8'h11, 1, 1'b1, 1);
            send_char(8'h12, 1, 1'b1, 1);
            send_char(8'h13, 1, 1'b1, 1);
            check(fifo_full == 1'b0 && rd_valid == 1'b1, "R11", "three held, not full",
                  int'({fifo_full, rd_valid}), 1);
            send_char(8'h14, 1, 1'b1, 1);
            check(fifo_full == 1'b1, "R11", "four held, full", int'(fifo_full), 1);
            check(n_ovr == o0, "R10", "no overrun yet", n_ovr - o0, 0);
            send_char(8'h15, 1, 1'b1, 1);
            check(n_ovr == o0 + 1, "R10", "overrun pulse", n_ovr - o0, 1);
            check(fifo_full == 1'b1, "R11", "still full after overrun", int'(fifo_full), 1);
            expect_ent(8'h11, 0, 0, 0, 0, "R9");
            expect_ent(8'h12, 0, 0, 0, 0, "R9");
            expect_ent(8'h13, 0, 0, 0, 0, "R9");
            expect_ent(8'h14, 0, 0, 1, 0, "R10");
            rd_go = 1'b1;
            drain("R9");
            check(fifo_full == 1'b0, "R11", "not full after drain", int'(fifo_full), 0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule